// File: doc/BRIEF.md
# External-Data SRAM Address Router

This block sits between a processor's external-data (MOVX-style) access path and two possible targets: a 1 KB on-chip data SRAM and an off-chip memory bus. For every access it decides, from the 16-bit data address, a fetch qualifier and a configuration enable bit, whether the byte lives on chip or off chip. It then carries out the read or write against that target and returns the read data from the target it chose.

The enable bit comes from a control register outside this block, and that register clears it on reset. While the bit is low, the whole 64 KB data space goes to the external bus. While it is high, the lowest 1 KB goes to the on-chip SRAM and the rest goes out. Instruction fetches never go to the SRAM. The scratchpad RAM has its own access path and never reaches this block.

A requester starts an access with a one-cycle `acc_req` while `acc_ready` is high. It sees completion as a one-cycle `acc_done`. The external side is a request/acknowledge port: `ext_req` stays high until the cycle in which `ext_ack` is sampled.

Top module: `xdata_router`

## Requirements
- R1: After a synchronous active-low reset, `acc_ready` is 1, `acc_done` is 0 and `ext_req` is 0.
- R2: While `cfg_ram_en` is 0, every data address from 0000h to FFFFh goes to the external bus: `ext_req` rises in the cycle after the access is accepted.
- R3: While `cfg_ram_en` is 1, a non-fetch access to 0000h–03FFh is served by the on-chip SRAM. `acc_done` goes high in the cycle after acceptance, `ext_req` stays 0, and a read returns the byte last written to that address.
- R4: While `cfg_ram_en` is 1, addresses 0400h–FFFFh go to the external bus.
- R5: An access with `acc_fetch` = 1 always goes to the external bus, whatever its address or the enable bit.
- R6: During an external access, `ext_req`, `ext_addr`, `ext_we` and `ext_wdata` hold steady until `ext_ack` is sampled high. `acc_done` stays 0 until then, and goes high in the following cycle. On a read, `acc_rdata` then equals the `ext_rdata` captured on the acknowledge edge.
- R7: The route is fixed when an access is accepted. A change of `cfg_ram_en` during an external access does not end or redirect it, and the new value applies from the next access.
- R8: Changing `cfg_ram_en` leaves the SRAM contents unchanged. A write to a low address made while the bit is 0 goes external and does not alter the on-chip byte.
- R9: `acc_ready` is 0 while an external access is outstanding. An `acc_req` pulse during that time is ignored: it starts no access and produces no extra `acc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ram_en | input | 1 | On-chip SRAM enable bit from the control register |
| acc_req | input | 1 | One-cycle access start, taken when `acc_ready` is 1 |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | 1 = instruction fetch, never routed on chip |
| acc_addr | input | 16 | Data address |
| acc_wdata | input | 8 | Write data |
| acc_ready | output | 1 | Block can accept an access |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 8 | Read data, valid with `acc_done` |
| ext_req | output | 1 | External bus request, held until acknowledged |
| ext_we | output | 1 | External write strobe qualifier |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_ack | input | 1 | External acknowledge |
| ext_rdata | input | 8 | External read data, sampled with `ext_ack` |

## Verification
The bench probes both edges of the on-chip window, 03FFh and 0400h, plus 0000h and FFFFh. An off-by-one in the range compare would send one of these to the wrong target. It flips the enable bit while an external access is waiting. A design that decoded the route live, instead of latching it, would then drop the request or return SRAM data. It writes a low address off chip while the SRAM is disabled and then reads it back on chip, which catches a design that gates the write with the address alone. It also pulses a request while the bus is busy, which exposes a design that accepts a second access or restarts the outstanding one.

// File: rtl/xr_pkg.sv
// Shared types for the external-data address router.
package xr_pkg;
    typedef enum logic {
        SRC_RAM = 1'b0,
        SRC_EXT = 1'b1
    } xr_src_e;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_WAIT = 1'b1
    } xr_state_e;
endpackage

// File: rtl/xr_decode.sv
// Route decoder: decides whether an access targets the on-chip SRAM.
// Assumes RAM_BYTES is a power of two smaller than 2**ADDR_W.
module xr_decode #(
    parameter int ADDR_W    = 16,
    parameter int RAM_BYTES = 1024,
    localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic              ram_en,
    input  logic              fetch,
    input  logic [ADDR_W-1:0] addr,
    output logic              onchip,
    output logic [RAM_AW-1:0] ram_idx
);
    // Low window, enabled, and not a fetch.
    always_comb begin
        onchip  = ram_en && !fetch && (addr[ADDR_W-1:RAM_AW] == '0);
        ram_idx = addr[RAM_AW-1:0];
    end
endmodule

// File: rtl/xr_sram.sv
// Single-port byte SRAM with a registered read port.
// Assumes the caller never asserts rd and wr together.
module xr_sram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage write; contents are not reset.
    always_ff @(posedge clk) begin
        if (wr) mem[idx] <= wdata;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= mem[idx];
    end
endmodule

// File: rtl/xr_ext_port.sv
// External-bus request/acknowledge sequencer.
// Latches one access at start, holds the request until it is acknowledged,
// then captures the read data. Assumes start only arrives while busy is low.
module xr_ext_port
    import xr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              busy,
    output logic              finish,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] rdata_cap
);
    xr_state_e state_q;

    // Idle/wait sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n)                             state_q <= XS_IDLE;
        else if (state_q == XS_IDLE && start)   state_q <= XS_WAIT;
        else if (state_q == XS_WAIT && ext_ack) state_q <= XS_IDLE;
    end

    // Latch the request fields when the access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_we    <= 1'b0;
            ext_addr  <= '0;
            ext_wdata <= '0;
        end else if (state_q == XS_IDLE && start) begin
            ext_we    <= we;
            ext_addr  <= addr;
            ext_wdata <= wdata;
        end
    end

    // Capture the returned byte on the acknowledge edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                             rdata_cap <= '0;
        else if (state_q == XS_WAIT && ext_ack) rdata_cap <= ext_rdata;
    end

    // Status decode.
    always_comb begin
        busy    = (state_q == XS_WAIT);
        ext_req = busy;
        finish  = busy && ext_ack;
    end
endmodule

// File: rtl/xdata_router.sv
// External-data address router: sends each data access either to the
// on-chip SRAM (low window, when enabled, non-fetch) or to the external bus.
// The route is fixed when the access is accepted.
// Assumes the enable bit's register clears it on reset.
module xdata_router
    import xr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int RAM_BYTES = 1024,
    localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ram_en,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic              acc_fetch,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              acc_done,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata
);
    logic              accept;
    logic              onchip;
    logic [RAM_AW-1:0] ram_idx;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] ext_cap;
    logic              ext_busy;
    logic              ext_fin;
    logic              done_q;
    xr_src_e           src_q;

    xr_decode #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES)) u_dec (
        .ram_en (cfg_ram_en),
        .fetch  (acc_fetch),
        .addr   (acc_addr),
        .onchip (onchip),
        .ram_idx(ram_idx)
    );

    xr_sram #(.DATA_W(DATA_W), .DEPTH(RAM_BYTES)) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (accept && onchip && acc_we),
        .rd   (accept && onchip && !acc_we),
        .idx  (ram_idx),
        .wdata(acc_wdata),
        .rdata(ram_rdata)
    );

    xr_ext_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && !onchip),
        .we       (acc_we),
        .addr     (acc_addr),
        .wdata    (acc_wdata),
        .ext_ack  (ext_ack),
        .ext_rdata(ext_rdata),
        .busy     (ext_busy),
        .finish   (ext_fin),
        .ext_req  (ext_req),
        .ext_we   (ext_we),
        .ext_addr (ext_addr),
        .ext_wdata(ext_wdata),
        .rdata_cap(ext_cap)
    );

    // Acceptance gating.
    always_comb begin
        acc_ready = !ext_busy;
        accept    = acc_req && acc_ready;
    end

    // Completion pulse and data source of the last accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            src_q  <= SRC_RAM;
        end else begin
            done_q <= (accept && onchip) || ext_fin;
            if (accept) src_q <= onchip ? SRC_RAM : SRC_EXT;
        end
    end

    // Return-data select.
    always_comb begin
        acc_done  = done_q;
        acc_rdata = (src_q == SRC_RAM) ? ram_rdata : ext_cap;
    end

    AST_DISABLED_GOES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cfg_ram_en |=> ext_req); // R2
    AST_ONCHIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cfg_ram_en && !acc_fetch && (acc_addr < ADDR_W'(RAM_BYTES)) |=> acc_done && !ext_req); // R3
    AST_HIGH_GOES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (acc_addr >= ADDR_W'(RAM_BYTES)) |=> ext_req); // R4
    AST_FETCH_GOES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        accept && acc_fetch |=> ext_req); // R5
    AST_EXT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_we) && $stable(ext_wdata)); // R6
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_ack |=> !acc_done); // R6
    AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && ext_ack |=> acc_done && !ext_req); // R6
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> !acc_ready); // R9
endmodule

// File: tb/xdata_router_tb_top.sv
module xdata_router_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ram_en = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic        acc_fetch = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        acc_ready, acc_done;
    logic [7:0]  acc_rdata;
    logic        ext_req, ext_we;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic        ext_ack = 1'b0;
    logic [7:0]  ext_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xdata_router dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ram_en(cfg_ram_en),
        .acc_req(acc_req), .acc_we(acc_we), .acc_fetch(acc_fetch),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_ready(acc_ready), .acc_done(acc_done), .acc_rdata(acc_rdata),
        .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_rdata(ext_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One access. to_ext selects the expected route; lat = wait cycles before ack.
    // flip_en toggles the enable bit and poke pulses acc_req while waiting.
    task automatic access(input string tag, input bit we, input bit fetch,
                          input logic [15:0] a, input logic [7:0] wd,
                          input bit to_ext, input int lat, input logic [7:0] ext_rd,
                          input logic [7:0] exp_rd, input bit flip_en, input bit poke);
        @(negedge clk);
        acc_req = 1; acc_we = we; acc_fetch = fetch; acc_addr = a; acc_wdata = wd;
        @(negedge clk);
        acc_req = 0;
        if (to_ext) begin
            chk({tag, " ext_req"}, ext_req, 1);
            chk({tag, " ext_addr"}, ext_addr, a);
            chk({tag, " ext_we"}, ext_we, we);
            if (we) chk({tag, " ext_wdata"}, ext_wdata, wd);
            chk({tag, " early done"}, acc_done, 0);
            for (int i = 0; i < lat; i++) begin
                if (i == 0 && flip_en) cfg_ram_en = ~cfg_ram_en;
                if (i == 0 && poke) begin acc_req = 1; acc_addr = 16'h0005; acc_fetch = 0; end
                if (i == 1) acc_req = 0;
                @(negedge clk);
                chk({tag, " R6 held req"}, ext_req, 1);
                chk({tag, " R6 held addr"}, ext_addr, a);
                chk({tag, " R9 not ready"}, acc_ready, 0);
                chk({tag, " R6 no done"}, acc_done, 0);
            end
            acc_req = 0;
            ext_ack = 1; ext_rdata = ext_rd;
            @(negedge clk);
            ext_ack = 0; ext_rdata = 8'h00;
            chk({tag, " R6 done"}, acc_done, 1);
            chk({tag, " R6 req drop"}, ext_req, 0);
            if (!we) chk({tag, " R6 rdata"}, acc_rdata, ext_rd);
            @(negedge clk);
            chk({tag, " R9 single done"}, acc_done, 0);
            chk({tag, " R9 no extra req"}, ext_req, 0);
        end else begin
            chk({tag, " R3 done"}, acc_done, 1);
            chk({tag, " R3 no ext"}, ext_req, 0);
            if (!we) chk({tag, " R3 rdata"}, acc_rdata, exp_rd);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ready", acc_ready, 1);
        chk("R1 done", acc_done, 0);
        chk("R1 ext_req", ext_req, 0);
    endtask

    task automatic t_disabled();
        cfg_ram_en = 0;
        access("R2 wr 0010", 1, 0, 16'h0010, 8'hA1, 1, 2, 8'h00, 8'h00, 0, 0);
        access("R2 rd 0000", 0, 0, 16'h0000, 8'h00, 1, 1, 8'h5A, 8'h00, 0, 0);
        access("R2 rd 03FF", 0, 0, 16'h03FF, 8'h00, 1, 0, 8'hC7, 8'h00, 0, 0);
    endtask

    task automatic t_onchip();
        cfg_ram_en = 1;
        access("R3 wr 0000", 1, 0, 16'h0000, 8'h11, 0, 0, 8'h00, 8'h00, 0, 0);
        access("R3 wr 03FF", 1, 0, 16'h03FF, 8'h22, 0, 0, 8'h00, 8'h00, 0, 0);
        access("R3 wr 0200", 1, 0, 16'h0200, 8'h33, 0, 0, 8'h00, 8'h00, 0, 0);
        access("R3 rd 0000", 0, 0, 16'h0000, 8'h00, 0, 0, 8'h00, 8'h11, 0, 0);
        access("R3 rd 03FF", 0, 0, 16'h03FF, 8'h00, 0, 0, 8'h00, 8'h22, 0, 0);
        access("R3 rd 0200", 0, 0, 16'h0200, 8'h00, 0, 0, 8'h00, 8'h33, 0, 0);
    endtask

    task automatic t_upper();
        cfg_ram_en = 1;
        access("R4 rd 0400", 0, 0, 16'h0400, 8'h00, 1, 1, 8'h44, 8'h00, 0, 0);
        access("R4 wr FFFF", 1, 0, 16'hFFFF, 8'h9E, 1, 2, 8'h00, 8'h00, 0, 0);
        access("R4 rd 8000", 0, 0, 16'h8000, 8'h00, 1, 0, 8'h3C, 8'h00, 0, 0);
    endtask

    task automatic t_fetch();
        cfg_ram_en = 1;
        access("R5 fetch 0010", 0, 1, 16'h0010, 8'h00, 1, 1, 8'h6B, 8'h00, 0, 0);
        access("R5 fetch 0000", 0, 1, 16'h0000, 8'h00, 1, 0, 8'h02, 8'h00, 0, 0);
    endtask

    task automatic t_en_change();
        cfg_ram_en = 1;
        access("R7 seed 0020", 1, 0, 16'h0020, 8'h77, 0, 0, 8'h00, 8'h00, 0, 0);
        cfg_ram_en = 0;
        // Enable rises while this external read waits; it must stay external.
        access("R7 mid flip", 0, 0, 16'h0020, 8'h00, 1, 3, 8'hE4, 8'h00, 1, 0);
        chk("R7 en now set", cfg_ram_en, 1);
        access("R7 next onchip", 0, 0, 16'h0020, 8'h00, 0, 0, 8'h00, 8'h77, 0, 0);
        // Enable falls during an external access to a high address.
        access("R7 mid clear", 0, 0, 16'h1234, 8'h00, 1, 2, 8'h81, 8'h00, 1, 0);
        access("R7 next ext", 0, 0, 16'h0020, 8'h00, 1, 0, 8'h0F, 8'h00, 0, 0);
    endtask

    task automatic t_retain();
        cfg_ram_en = 1;
        access("R8 seed 0100", 1, 0, 16'h0100, 8'hC3, 0, 0, 8'h00, 8'h00, 0, 0);
        cfg_ram_en = 0;
        access("R8 ext wr 0100", 1, 0, 16'h0100, 8'hFF, 1, 1, 8'h00, 8'h00, 0, 0);
        cfg_ram_en = 1;
        access("R8 readback 0100", 0, 0, 16'h0100, 8'h00, 0, 0, 8'h00, 8'hC3, 0, 0);
        access("R8 readback 0000", 0, 0, 16'h0000, 8'h00, 0, 0, 8'h00, 8'h11, 0, 0);
    endtask

    task automatic t_busy();
        cfg_ram_en = 0;
        access("R9 poke", 0, 0, 16'h0700, 8'h00, 1, 3, 8'hB2, 8'h00, 0, 1);
        cfg_ram_en = 1;
        access("R9 after", 0, 0, 16'h0200, 8'h00, 0, 0, 8'h00, 8'h33, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_onchip();
        t_upper();
        t_fetch();
        t_en_change();
        t_retain();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule